// File: doc/BRIEF.md
# Static memory bus-cycle timing generator

This block produces the active-low chip-select, write-strobe and read-strobe waveforms for a single access to an external static memory. A small number of chip selects is supported. Each chip select owns three configuration words: one holding the setup delays, one holding the pulse widths and one holding the cycle lengths. Software or a bus bridge loads these words through a plain register-write port.

Every timing field uses a compressed two-range format. A few high bits count large blocks of clock cycles and the low bits count single cycles. At the start of an access the block expands the fields for the requested chip select and direction into linear counts. A single counter then walks the access from the first cycle to the last. Each access is started with a request while `ready` is high, and it ends with a one-clock `done` pulse.

Top module: `static_bus_timer`

## Requirements
- R1: After reset, every configuration word of every chip select is zero, `cs_n`, `we_n` and `rd_n` are all high, `ready` is high and `done` is low. An access on a chip select that was never written therefore lasts one cycle, and no strobe or chip select goes low during it.
- R2: A setup field is the low 6 bits of its byte slot. It decodes to 128 × bit5 + bits[4:0] cycles. Counting the first cycle after acceptance as cycle 0, the signal goes low in the cycle whose number equals the decoded setup.
- R3: A pulse field is the low 7 bits of its byte slot. It decodes to 256 × bit6 + bits[5:0] cycles, which is how many consecutive cycles the signal stays low.
- R4: A cycle field is 9 bits wide. It decodes to 256 × bits[8:7] + bits[6:0] cycles. The access lasts that many cycles, with a minimum of one, and `done` is high only in the last of them.
- R5: A decoded pulse of zero keeps that signal high for the whole access.
- R6: When setup + pulse reaches past the end of the access, the signal returns high as soon as the access ends.
- R7: Read and write use separate fields. The setup and pulse words have byte slots [7:0] for the write strobe, [15:8] for the chip select during writes, [23:16] for the read strobe and [31:24] for the chip select during reads. The cycle word has the write length in [8:0] and the read length in [24:16]. Bits above each field inside its slot are ignored. A write access never drives `rd_n` low and a read access never drives `we_n` low.
- R8: Each chip select has its own words. `cfg_sel` picks the word: 0 for setup, 1 for pulse, 2 for cycle. Value 3 changes nothing. Only the `cs_n` bit of the accessed chip select can go low.
- R9: A request is accepted only on a clock edge where `ready` is high. `ready` is low for the whole access, and requests made during that time are ignored. `ready` is high again in the cycle after `done`.
- R10: A configuration write takes effect at the next accepted access. This also covers a write to the chip select whose access is running, and a write made in the same cycle as acceptance. It never changes an access already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cs | input | CSW | Chip select whose word is written |
| cfg_sel | input | 2 | Word select: 0 setup, 1 pulse, 2 cycle, 3 none |
| cfg_data | input | 32 | Configuration word |
| req | input | 1 | Access request |
| req_cs | input | CSW | Chip select of the request |
| req_wr | input | 1 | 1 for write access, 0 for read |
| ready | output | 1 | High when a request can be accepted |
| done | output | 1 | High in the last cycle of an access |
| cs_n | output | NUM_CS | Active-low chip selects |
| we_n | output | 1 | Active-low write strobe |
| rd_n | output | 1 | Active-low read strobe |

## Verification
Each table entry programs one chip select and runs one access. The bench then compares every output in every cycle of that access against waveforms it computes from the field formulas. The patterns are chosen to separate specific faults:
- Short linear values check the low bits of each field.
- Values with the high-range bits set catch a wrong weight or bit position in a decode.
- Words with junk above each field, or with the other direction's slots filled, expose slot mix-ups and read/write crossover.
- A zero cycle word, a zero pulse, and windows longer than the cycle cover the minimum length, the silent signal and truncation.

Directed runs follow the table:
- A run on unprogrammed registers after reset.
- A foreign request held during a busy access.
- A configuration write landing mid-access.

// File: rtl/static_bus_timer.sv
module static_bus_timer #(
  parameter int NUM_CS = 4,
  parameter int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CSW-1:0]    cfg_cs,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_data,
  input  logic              req,
  input  logic [CSW-1:0]    req_cs,
  input  logic              req_wr,
  output logic              ready,
  output logic              done,
  output logic [NUM_CS-1:0] cs_n,
  output logic              we_n,
  output logic              rd_n
);

  localparam int CW = 10;

  function automatic logic [CW-1:0] dec_setup(input logic [7:0] f);
    return {2'b00, f[5], 2'b00, f[4:0]};
  endfunction

  function automatic logic [CW-1:0] dec_pulse(input logic [7:0] f);
    return {1'b0, f[6], 2'b00, f[5:0]};
  endfunction

  function automatic logic [CW-1:0] dec_cycle(input logic [8:0] f);
    return {f[8:7], 1'b0, f[6:0]};
  endfunction

  logic [31:0] setup_w [NUM_CS];
  logic [31:0] pulse_w [NUM_CS];
  logic [31:0] cycle_w [NUM_CS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CS; i++) begin
        setup_w[i] <= '0;
        pulse_w[i] <= '0;
        cycle_w[i] <= '0;
      end
    end else if (cfg_we && int'(cfg_cs) < NUM_CS) begin
      case (cfg_sel)
        2'd0: setup_w[cfg_cs] <= cfg_data;
        2'd1: pulse_w[cfg_cs] <= cfg_data;
        2'd2: cycle_w[cfg_cs] <= cfg_data;
        default: ;
      endcase
    end
  end

  logic [31:0] sel_setup, sel_pulse, sel_cycle;
  assign sel_setup = setup_w[req_cs];
  assign sel_pulse = pulse_w[req_cs];
  assign sel_cycle = cycle_w[req_cs];

  logic [7:0] st_sf, st_pf, cs_sf, cs_pf;
  logic [8:0] cyc_f;
  assign st_sf = req_wr ? sel_setup[7:0]   : sel_setup[23:16];
  assign cs_sf = req_wr ? sel_setup[15:8]  : sel_setup[31:24];
  assign st_pf = req_wr ? sel_pulse[7:0]   : sel_pulse[23:16];
  assign cs_pf = req_wr ? sel_pulse[15:8]  : sel_pulse[31:24];
  assign cyc_f = req_wr ? sel_cycle[8:0]   : sel_cycle[24:16];

  logic [CW-1:0] cyc_len;
  assign cyc_len = dec_cycle(cyc_f);

  logic           busy, wr_q;
  logic [CSW-1:0] cs_q;
  logic [CW-1:0]  cnt, last_q, st_on_q, st_off_q, cs_on_q, cs_off_q;
  logic           accept;

  assign ready  = !busy;
  assign accept = req && ready;
  assign done   = busy && (cnt == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      wr_q     <= 1'b0;
      cs_q     <= '0;
      cnt      <= '0;
      last_q   <= '0;
      st_on_q  <= '0;
      st_off_q <= '0;
      cs_on_q  <= '0;
      cs_off_q <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      wr_q     <= req_wr;
      cs_q     <= req_cs;
      cnt      <= '0;
      last_q   <= (cyc_len == '0) ? '0 : cyc_len - 1'b1;
      st_on_q  <= dec_setup(st_sf);
      st_off_q <= dec_setup(st_sf) + dec_pulse(st_pf);
      cs_on_q  <= dec_setup(cs_sf);
      cs_off_q <= dec_setup(cs_sf) + dec_pulse(cs_pf);
    end else if (busy) begin
      if (cnt == last_q) busy <= 1'b0;
      else               cnt  <= cnt + 1'b1;
    end
  end

  logic st_act, cs_act;
  assign st_act = busy && (cnt >= st_on_q) && (cnt < st_off_q);
  assign cs_act = busy && (cnt >= cs_on_q) && (cnt < cs_off_q);

  assign we_n = !(st_act && wr_q);
  assign rd_n = !(st_act && !wr_q);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = !(cs_act && (cs_q == CSW'(g)));
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (&cs_n && we_n && rd_n)) else $error("idle outputs active"); // R1
  AST_DIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !rd_n)) else $error("both strobes low"); // R7
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n)) else $error("several chip selects low"); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && ready)) else $error("done not single"); // R4
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !done) |=> !ready) else $error("access cut short"); // R9
  AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !done) |=> ($stable(st_off_q) && $stable(cs_off_q) && $stable(last_q)))
    else $error("timing changed mid access"); // R10

endmodule

// File: tb/static_bus_timer_test.sv
module static_bus_timer_test;
  localparam int NUM_CS = 4;
  localparam int CSW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [CSW-1:0] cfg_cs = '0;
  logic [1:0] cfg_sel = '0;
  logic [31:0] cfg_data = '0;
  logic req = 1'b0;
  logic [CSW-1:0] req_cs = '0;
  logic req_wr = 1'b0;
  logic ready, done, we_n, rd_n;
  logic [NUM_CS-1:0] cs_n;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  static_bus_timer #(.NUM_CS(NUM_CS), .CSW(CSW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cs(cfg_cs), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .req(req), .req_cs(req_cs), .req_wr(req_wr),
    .ready(ready), .done(done), .cs_n(cs_n), .we_n(we_n), .rd_n(rd_n));

  localparam int NV = 8;
  localparam int V_CS [NV] = '{0, 1, 2, 3, 0, 1, 2, 3};
  localparam bit V_WR [NV] = '{1, 0, 1, 0, 0, 1, 1, 0};
  localparam logic [31:0] V_SET [NV] = '{
    32'h0000_0002, 32'h0001_0505, 32'h0000_0021, 32'h0005_0000,
    32'h0300_0000, 32'h0000_C1C3, 32'h0000_0000, 32'h0020_0000};
  localparam logic [31:0] V_PUL [NV] = '{
    32'h0000_0603, 32'h0704_0505, 32'h0000_7F42, 32'h0014_0000,
    32'h0400_0000, 32'h0000_8582, 32'h0000_0101, 32'h4140_0000};
  localparam logic [31:0] V_CYC [NV] = '{
    32'h0000_0008, 32'h0009_0003, 32'h0000_0185, 32'h000A_0000,
    32'h0006_0000, 32'hFE00_FE06, 32'h0000_0000, 32'h0080_0000};

  function automatic int d_set(input logic [7:0] b);
    return (b[5] ? 128 : 0) + int'(b[4:0]);
  endfunction
  function automatic int d_pul(input logic [7:0] b);
    return (b[6] ? 256 : 0) + int'(b[5:0]);
  endfunction
  function automatic int d_cyc(input logic [8:0] c);
    return 256 * int'(c[8:7]) + int'(c[6:0]);
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int cs, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_cs = CSW'(cs); cfg_sel = 2'(sel); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // mid: 0 none, 1 pulse rewrite at t=2, 2 foreign request t=2..4
  task automatic run_access(input int cs, input bit wr, input logic [31:0] sw,
                            input logic [31:0] pw, input logic [31:0] cw,
                            input string rq, input int mid, input logic [31:0] mid_d);
    int ss, sp, cs_s, cs_p, len, miss, fa, fe;
    logic [7:0] sb, cb, pb, qb;
    logic [8:0] cf;
    sb = wr ? sw[7:0] : sw[23:16];
    cb = wr ? sw[15:8] : sw[31:24];
    pb = wr ? pw[7:0] : pw[23:16];
    qb = wr ? pw[15:8] : pw[31:24];
    cf = wr ? cw[8:0] : cw[24:16];
    ss = d_set(sb); sp = d_pul(pb); cs_s = d_set(cb); cs_p = d_pul(qb);
    len = d_cyc(cf); if (len == 0) len = 1;
    miss = 0; fa = 0; fe = 0;
    @(negedge clk);
    req = 1'b1; req_cs = CSW'(cs); req_wr = wr;
    @(negedge clk);
    req = 1'b0;
    for (int t = 0; t < len; t++) begin
      bit es, ec;
      logic [NUM_CS-1:0] ecs;
      logic [4+NUM_CS-1:0] av, ev;
      es = (t >= ss) && (t < ss + sp);
      ec = (t >= cs_s) && (t < cs_s + cs_p);
      ecs = ec ? ~(NUM_CS'(1) << cs) : '1;
      ev = {!(es && wr), !(es && !wr), (t == len - 1), 1'b0, ecs};
      av = {we_n, rd_n, done, ready, cs_n};
      if (av !== ev) begin
        if (miss == 0) begin fa = int'(av); fe = int'(ev); end
        miss++;
      end
      if (mid == 1 && t == 2) begin cfg_we = 1'b1; cfg_cs = CSW'(cs); cfg_sel = 2'd1; cfg_data = mid_d; end
      if (mid == 1 && t == 3) cfg_we = 1'b0;
      if (mid == 2 && t == 2) begin req = 1'b1; req_cs = CSW'((cs + 1) % NUM_CS); req_wr = !wr; end
      if (mid == 2 && t == 4) req = 1'b0;
      if (t < len - 1) @(negedge clk);
    end
    check(miss == 0, rq, "waveform {we_n,rd_n,done,ready,cs_n}", fa, fe);
    @(negedge clk);
    check(ready === 1'b1 && done === 1'b0 && we_n && rd_n && &cs_n, "R9",
          "ready after done", int'({ready, done}), 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ready === 1'b1 && done === 1'b0 && we_n && rd_n && &cs_n, "R1",
          "reset outputs", int'({ready, done, we_n, rd_n, cs_n}), int'({4'b1011, 4'hF}));
    rst_n = 1'b1;
    @(negedge clk);
    // R1: unwritten registers give a one-cycle silent access
    run_access(3, 1'b0, 32'h0, 32'h0, 32'h0, "R1", 0, 32'h0);

    // table: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      cfg_write(V_CS[v], 0, V_SET[v]);
      cfg_write(V_CS[v], 1, V_PUL[v]);
      cfg_write(V_CS[v], 2, V_CYC[v]);
      run_access(V_CS[v], V_WR[v], V_SET[v], V_PUL[v], V_CYC[v],
                 $sformatf("R2/R3/R4/R5/R6/R7 vec%0d", v), 0, 32'h0);
    end

    // R8: selector 3 writes nothing; vector 0 timing still holds on cs0
    cfg_write(0, 0, V_SET[0]);
    cfg_write(0, 1, V_PUL[0]);
    cfg_write(0, 2, V_CYC[0]);
    cfg_write(0, 3, 32'hFFFF_FFFF);
    run_access(0, 1'b1, V_SET[0], V_PUL[0], V_CYC[0], "R8 sel3", 0, 32'h0);

    // R8: cs1 words untouched by cs0 writes (vector 5 still in cs1)
    run_access(1, 1'b1, V_SET[5], V_PUL[5], V_CYC[5], "R8 per-cs", 0, 32'h0);

    // R10: pulse rewritten mid access; current uses old, next uses new
    run_access(0, 1'b1, V_SET[0], V_PUL[0], V_CYC[0], "R10 old", 1, 32'h0000_0101);
    run_access(0, 1'b1, V_SET[0], 32'h0000_0101, V_CYC[0], "R10 new", 0, 32'h0);

    // R9: foreign request during busy access is ignored
    cfg_write(1, 0, 32'h0000_0000);
    cfg_write(1, 1, 32'h0505_0505);
    cfg_write(1, 2, 32'h0005_0005);
    run_access(0, 1'b1, V_SET[0], 32'h0000_0101, V_CYC[0], "R9 busy", 2, 32'h0);
    for (int k = 0; k < 3; k++) begin
      check(ready === 1'b1 && &cs_n && we_n && rd_n, "R9", "held-off request started",
            int'({ready, cs_n}), int'({1'b1, 4'hF}));
      @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule